// File: doc/BRIEF.md
# Variable-Step Signed-Digit Result Accumulator

This block assembles a non-redundant fixed-point result from a stream of signed digits produced by a digit-recurrence unit whose cycles come in three kinds. In a full-advance cycle the result moves on by one whole digit of log2 r bits. In a partial-advance cycle it moves on by a shorter step of log2 p bits. In a correction cycle the digit lands at the weight of the digit it repairs. Because the step size varies, a digit can overlap the bits of earlier digits. Every digit is therefore summed into the running value rather than appended.

The position weight is held as a shift count. Before a digit is weighted, the count grows by the step of the cycle kind. The digit is then scaled by 2 to the power minus the count and added to a wide two's-complement register with FRAC_W fractional bits. A start pulse opens a new operation. Once the shift count has covered the target precision, the block flags completion and ignores further digits. The running result is always visible at the output.

Top module: `vadv_digit_accum`

## Requirements
- R1: After reset, result is 0, shift_pos is 0 and done is 0.
- R2: A start pulse clears result and shift_pos on the next clock edge. Start takes priority over a digit presented in the same cycle.
- R3: A digit with dig_kind 2'b01 (full advance) first raises shift_pos by LOG2_R and is then weighted by 2^-shift_pos.
- R4: A digit with dig_kind 2'b10 (partial advance) first raises shift_pos by LOG2_P and is then weighted by 2^-shift_pos.
- R5: A digit with dig_kind 2'b00 (correction) leaves shift_pos unchanged and is added at the current weight.
- R6: An accepted digit d at shift s adds floor(d * 2^(FRAC_W - s)) to result, read as a two's-complement integer in units of 2^-FRAC_W. Bits below 2^-FRAC_W are dropped toward minus infinity.
- R7: done is 1 exactly when shift_pos >= FRAC_W. While done is 1, digits change neither result nor shift_pos.
- R8: A digit with dig_kind 2'b11 is ignored.
- R9: result wraps modulo 2^ACC_W, where ACC_W = DIGIT_W + 2 + FRAC_W.
- R10: In a cycle with dig_valid and start both low, result and shift_pos hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new operation: clear result and shift count |
| dig_valid | input | 1 | A digit is presented this cycle |
| dig_kind | input | 2 | Cycle kind: 00 correction, 01 full, 10 partial, 11 ignored |
| dig_val | input | DIGIT_W | Signed digit value |
| result | output | ACC_W | Running two's-complement result, FRAC_W fractional bits |
| shift_pos | output | CNT_W | Current weight exponent (weight = 2^-shift_pos) |
| done | output | 1 | Target precision covered |

## Verification
The bench builds the block with LOG2_R = 4, LOG2_P = 2 and DIGIT_W = 6, and shrinks FRAC_W to 12. With these values completion is reached after only three full digits. A full step from shift 10 overshoots to 14, which exercises the truncation of fine bits for both positive and negative digits. The integer field is only eight bits wide, so a short run of large correction digits at shift 0 is enough to drive the result past its range and show the wrap.

// File: rtl/vadv_pkg.sv
package vadv_pkg;
  typedef enum logic [1:0] {
    KIND_SAME = 2'b00,
    KIND_FULL = 2'b01,
    KIND_PART = 2'b10,
    KIND_NONE = 2'b11
  } kind_e;
endpackage

// File: rtl/vadv_weight_track.sv
module vadv_weight_track #(
  parameter int LOG2_R = 4,
  parameter int LOG2_P = 2,
  parameter int FRAC_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [1:0]       kind,
  output logic [CNT_W-1:0] shift_q,
  output logic [CNT_W-1:0] shift_nxt,
  output logic             covered
);
  import vadv_pkg::*;

  function automatic logic [CNT_W-1:0] step_from(input logic [1:0] k,
                                                 input logic [CNT_W-1:0] cur);
    case (kind_e'(k))
      KIND_FULL: step_from = cur + CNT_W'(LOG2_R);
      KIND_PART: step_from = cur + CNT_W'(LOG2_P);
      default:   step_from = cur;
    endcase
  endfunction

  assign shift_nxt = step_from(kind, shift_q);
  assign covered   = (shift_q >= CNT_W'(FRAC_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shift_q <= '0;
    else if (clr)  shift_q <= '0;
    else if (take) shift_q <= shift_nxt;
  end
endmodule

// File: rtl/vadv_sum_reg.sv
module vadv_sum_reg #(
  parameter int DIGIT_W = 6,
  parameter int FRAC_W  = 24,
  parameter int ACC_W   = 32,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               take,
  input  logic [DIGIT_W-1:0] digit,
  input  logic [CNT_W-1:0]   weight_exp,
  output logic [ACC_W-1:0]   acc_q
);
  function automatic logic [ACC_W-1:0] scaled_term(input logic [DIGIT_W-1:0] d,
                                                   input logic [CNT_W-1:0] s);
    logic signed [ACC_W-1:0] ext;
    ext = {{(ACC_W-DIGIT_W){d[DIGIT_W-1]}}, d};
    ext = ext <<< FRAC_W;
    scaled_term = ext >>> s;
  endfunction

  logic [ACC_W-1:0] term_w;
  assign term_w = scaled_term(digit, weight_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (clr)  acc_q <= '0;
    else if (take) acc_q <= acc_q + term_w;
  end
endmodule

// File: rtl/vadv_digit_accum.sv
module vadv_digit_accum #(
  parameter int LOG2_R  = 4,
  parameter int LOG2_P  = 2,
  parameter int DIGIT_W = 6,
  parameter int FRAC_W  = 24,
  localparam int ACC_W  = DIGIT_W + 2 + FRAC_W,
  localparam int CNT_W  = $clog2(FRAC_W + LOG2_R + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dig_valid,
  input  logic [1:0]         dig_kind,
  input  logic [DIGIT_W-1:0] dig_val,
  output logic [ACC_W-1:0]   result,
  output logic [CNT_W-1:0]   shift_pos,
  output logic               done
);
  import vadv_pkg::*;

  logic             accept_w;
  logic [CNT_W-1:0] shift_nxt_w;

  assign accept_w = dig_valid && !start && !done && (kind_e'(dig_kind) != KIND_NONE);

  vadv_weight_track #(
    .LOG2_R(LOG2_R), .LOG2_P(LOG2_P), .FRAC_W(FRAC_W), .CNT_W(CNT_W)
  ) trk_i (
    .clk(clk), .rst_n(rst_n), .clr(start), .take(accept_w), .kind(dig_kind),
    .shift_q(shift_pos), .shift_nxt(shift_nxt_w), .covered(done)
  );

  vadv_sum_reg #(
    .DIGIT_W(DIGIT_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
  ) sum_i (
    .clk(clk), .rst_n(rst_n), .clr(start), .take(accept_w), .digit(dig_val),
    .weight_exp(shift_nxt_w), .acc_q(result)
  );
endmodule

// File: rtl/vadv_digit_accum_chk.sv
module vadv_digit_accum_chk #(
  parameter int LOG2_R = 4,
  parameter int LOG2_P = 2,
  parameter int FRAC_W = 24,
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             dig_valid,
  input logic [1:0]       dig_kind,
  input logic [ACC_W-1:0] result,
  input logic [CNT_W-1:0] shift_pos,
  input logic             done,
  input logic             accept_w
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (result == '0 && shift_pos == '0)); // R2
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && dig_kind == 2'b01) |=> (shift_pos == $past(shift_pos) + CNT_W'(LOG2_R))); // R3
  AST_PART_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && dig_kind == 2'b10) |=> (shift_pos == $past(shift_pos) + CNT_W'(LOG2_P))); // R4
  AST_SAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && !start && dig_kind == 2'b00) |=> $stable(shift_pos)); // R5
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(result) && $stable(shift_pos))); // R7
  AST_KIND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && !start && dig_kind == 2'b11) |=> ($stable(result) && $stable(shift_pos))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dig_valid && !start) |=> ($stable(result) && $stable(shift_pos))); // R10
  AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pos < CNT_W'(FRAC_W + LOG2_R)); // R7
endmodule

bind vadv_digit_accum vadv_digit_accum_chk #(
  .LOG2_R(LOG2_R), .LOG2_P(LOG2_P), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .dig_valid(dig_valid),
  .dig_kind(dig_kind), .result(result), .shift_pos(shift_pos), .done(done),
  .accept_w(accept_w)
);

// File: tb/vadv_digit_accum_tb_top.sv
`timescale 1ns/1ps
module vadv_digit_accum_tb_top;
  localparam int LR = 4;
  localparam int LP = 2;
  localparam int DW = 6;
  localparam int FW = 12;
  localparam int AW = DW + 2 + FW;
  localparam int CW = $clog2(FW + LR + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic dig_valid = 1'b0;
  logic [1:0] dig_kind = 2'b00;
  logic [DW-1:0] dig_val = '0;
  logic [AW-1:0] result;
  logic [CW-1:0] shift_pos;
  logic done;

  always #2.5 clk = ~clk;

  vadv_digit_accum #(.LOG2_R(LR), .LOG2_P(LP), .DIGIT_W(DW), .FRAC_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dig_valid(dig_valid),
    .dig_kind(dig_kind), .dig_val(dig_val), .result(result),
    .shift_pos(shift_pos), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  longint m_res = 0;
  int m_sh = 0;

  typedef struct packed {
    logic       st;
    logic       vl;
    logic [1:0] kd;
    logic [5:0] dg;
    logic [4:0] xsh;
    logic       xdn;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b1, 1'b0, 2'b00, 6'd0,  5'd0,  1'b0},  // R2 open
    '{1'b0, 1'b1, 2'b01, 6'd7,  5'd4,  1'b0},  // R3
    '{1'b0, 1'b1, 2'b01, 6'h3E, 5'd8,  1'b0},  // R3 digit -2
    '{1'b0, 1'b1, 2'b10, 6'd3,  5'd10, 1'b0},  // R4
    '{1'b0, 1'b1, 2'b00, 6'h3F, 5'd10, 1'b0},  // R5 digit -1
    '{1'b0, 1'b1, 2'b01, 6'd5,  5'd14, 1'b1},  // R6 overshoot truncation, R7
    '{1'b0, 1'b1, 2'b01, 6'd3,  5'd14, 1'b1},  // R7 ignored after done
    '{1'b1, 1'b0, 2'b00, 6'd0,  5'd0,  1'b0},  // R2
    '{1'b0, 1'b1, 2'b01, 6'h38, 5'd4,  1'b0},  // R3 digit -8
    '{1'b0, 1'b1, 2'b11, 6'd9,  5'd4,  1'b0},  // R8
    '{1'b0, 1'b1, 2'b10, 6'h21, 5'd6,  1'b0},  // R4 digit -31
    '{1'b0, 1'b1, 2'b10, 6'd31, 5'd8,  1'b0},  // R4 overlap
    '{1'b0, 1'b1, 2'b10, 6'h3B, 5'd10, 1'b0},  // R4 digit -5
    '{1'b0, 1'b1, 2'b10, 6'd1,  5'd12, 1'b1}   // R7 exact coverage
  };

  function automatic longint term_of(input longint d, input int s);
    longint k;
    if (s <= FW) return d * (longint'(1) << (FW - s));
    k = longint'(1) << (s - FW);
    if (d >= 0) return d / k;
    return (d - (k - 1)) / k;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic st, input logic vl, input logic [1:0] kd, input logic [DW-1:0] dg);
    longint dv;
    @(negedge clk);
    start = st; dig_valid = vl; dig_kind = kd; dig_val = dg;
    @(posedge clk);
    #1;
    start = 1'b0; dig_valid = 1'b0;
    dv = longint'($signed(dg));
    if (st) begin
      m_res = 0; m_sh = 0;
    end else if (vl && m_sh < FW && kd != 2'b11) begin
      if (kd == 2'b01) m_sh += LR;
      else if (kd == 2'b10) m_sh += LP;
      m_res += term_of(dv, m_sh);
    end
  endtask

  function automatic longint wrap(input longint v);
    return v & ((longint'(1) << AW) - 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(result == '0 && shift_pos == '0 && done == 1'b0, "R1 reset state",
          longint'(result), 0);
    @(negedge clk) rst_n = 1'b1;

    foreach (VECS[i]) begin
      apply(VECS[i].st, VECS[i].vl, VECS[i].kd, VECS[i].dg);
      check(longint'(result) == wrap(m_res), "R6 result", longint'(result), wrap(m_res));
      check(shift_pos == VECS[i].xsh, "R3/R4/R5 shift_pos", longint'(shift_pos), longint'(VECS[i].xsh));
      check(done == VECS[i].xdn, "R7 done", longint'(done), longint'(VECS[i].xdn));
    end

    // R10: idle cycles hold state
    @(negedge clk); @(negedge clk);
    check(longint'(result) == wrap(m_res) && shift_pos == 5'd12, "R10 idle hold",
          longint'(result), wrap(m_res));

    // R2: start beats a simultaneous digit
    apply(1'b1, 1'b1, 2'b01, 6'd9);
    check(result == '0 && shift_pos == '0, "R2 start priority", longint'(result), 0);

    // R9: large correction digits at shift 0 wrap the register
    for (int k = 0; k < 9; k++) apply(1'b0, 1'b1, 2'b00, 6'd31);
    check(longint'(result) == wrap(279 * 4096), "R9 wrap", longint'(result), wrap(279 * 4096));
    check(shift_pos == '0 && done == 1'b0, "R5 correction keeps shift", longint'(shift_pos), 0);

    // R6: negative digit truncated toward minus infinity
    apply(1'b1, 1'b0, 2'b00, 6'd0);
    apply(1'b0, 1'b1, 2'b01, 6'd0);
    apply(1'b0, 1'b1, 2'b01, 6'd0);
    apply(1'b0, 1'b1, 2'b10, 6'd0);
    apply(1'b0, 1'b1, 2'b01, 6'h3D);
    check(longint'(result) == wrap(-1), "R6 negative floor", longint'(result), wrap(-1));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule